// File: doc/BRIEF.md
# Infrared Pulse-Position Key Code Transmitter

This block turns a 12-bit key code into the drive signal for an infrared emitter. While a key is held it sends the code as a pulse-position-modulated frame on a 38 kHz carrier. The carrier is made by a parameterised divider of the system clock. Sixteen carrier periods form one time unit, and every interval in the output is a whole number of units. Each code bit lasts four units. The envelope of a one is high for the first three units of the bit, and the envelope of a zero is high for the first unit only. The output pin follows the carrier while the envelope is high and stays low at all other times.

When the key goes down, the block stores the code and waits a lead-in of 60 units. It then sends the frame, which is 48 units long, most significant bit first. The second copy of the frame starts 80 units after the first copy starts. While the key stays down, a new pair starts every 208 units. When the key is released, the block finishes the pair it has started and then goes silent. A new key press is accepted once the block is idle again.

Top module: `ir_ppm_encoder`

## Requirements
- R1: After reset, and while no key press has started a burst, `ir_drive` stays low, whatever `key_code` does.
- R2: A key press is a low-to-high change of `key_down` seen while idle. After the press, `ir_drive` stays low for exactly 60 units, where one unit is 16 carrier periods.
- R3: Each bit lasts 4 units. For a bit value of 1 the envelope is high for the first 3 units of the bit. For a bit value of 0 the envelope is high for the first unit only.
- R4: A frame is the 12 bits of the stored code, sent from bit 11 down to bit 0, with no gap between bits. A frame lasts 48 units.
- R5: The second copy of the frame starts 80 units after the first copy starts. The output is silent for the 32 units between the two copies.
- R6: While `key_down` stays high, the next pair starts 208 units after the previous pair started. The output is silent after the second copy until that next pair starts.
- R7: A release takes effect only at the end of the second copy of the current pair. After that the output stays low, and no frame is ever cut short.
- R8: The key code is captured on the press edge. Changes on `key_code` during a burst do not change the transmitted bits.
- R9: While the envelope is high, `ir_drive` is a square wave with a period of 2*HALF_DIV clocks. It starts high at the start of the burst, which restarts the carrier phase. While the envelope is low, `ir_drive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_down | input | 1 | High while a key is held |
| key_code | input | 12 | Key code, captured on the press edge |
| ir_drive | output | 1 | Carrier-gated drive signal for the emitter |

## Verification
A wrong unit or divider count moves every edge after the press, so the first frame's leading pulse shows up at the wrong cycle, 60 units after the press. A wrong bit index or a wrong compare against the duty value changes the pulse width within a single bit, so the error is visible inside the 4-unit bit window where it occurs. A wrong stop or wrap decision in the sequencer shows only at the end of a pair, either as a cut-short second copy or as an extra pair. For that reason the bench compares every cycle of the burst against an independent timing model and holds each run until well after the expected end.

// File: rtl/ir_ppm_pkg.sv
package ir_ppm_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_LEAD  = 2'd1,
        TX_BURST = 2'd2
    } tx_state_t;

    // Counter width that is never zero, even for a modulus of one
    function automatic int safe_width(input int modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int HALF_DIV = 658
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic carrier,
    output logic period_tick
);
    import ir_ppm_pkg::*;

    localparam int CW = safe_width(HALF_DIV);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] half_cnt;
    logic          phase;

    // A full carrier period ends when the low half finishes
    assign period_tick = (half_cnt == HALF_LAST) && !phase;
    assign carrier     = phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            half_cnt <= '0;
            phase    <= 1'b1;
        end else if (half_cnt == HALF_LAST) begin
            half_cnt <= '0;
            phase    <= !phase;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ir_unit_timer.sv
module ir_unit_timer #(
    parameter int UNIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic period_tick,
    output logic unit_stb
);
    import ir_ppm_pkg::*;

    localparam int TW = safe_width(UNIT_TICKS);
    localparam logic [TW-1:0] TICK_LAST = TW'(UNIT_TICKS - 1);

    logic [TW-1:0] tick_cnt;

    assign unit_stb = period_tick && (tick_cnt == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tick_cnt <= '0;
        end else if (period_tick) begin
            tick_cnt <= (tick_cnt == TICK_LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ir_frame_seq.sv
module ir_frame_seq #(
    parameter int KEY_BITS     = 12,
    parameter int BIT_UNITS    = 4,
    parameter int ONE_HIGH     = 3,
    parameter int ZERO_HIGH    = 1,
    parameter int LEAD_UNITS   = 60,
    parameter int REPEAT_UNITS = 80,
    parameter int PAIR_UNITS   = 208,
    parameter int UW           = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       key_down,
    input  logic [KEY_BITS-1:0]        key_code,
    input  logic                       unit_stb,
    output logic                       restart,
    output ir_ppm_pkg::tx_state_t      state,
    output logic [UW-1:0]              unit_cnt,
    output logic [KEY_BITS-1:0]        code_q,
    output logic                       envelope
);
    import ir_ppm_pkg::*;

    localparam int FRAME_UNITS = KEY_BITS * BIT_UNITS;
    localparam logic [UW-1:0] LEAD_LAST  = UW'(LEAD_UNITS - 1);
    localparam logic [UW-1:0] PAIR_LAST  = UW'(PAIR_UNITS - 1);
    localparam logic [UW-1:0] STOP_AT    = UW'(REPEAT_UNITS + FRAME_UNITS - 1);
    localparam logic [UW-1:0] FRAME_END  = UW'(FRAME_UNITS);
    localparam logic [UW-1:0] COPY_START = UW'(REPEAT_UNITS);
    localparam logic [UW-1:0] COPY_END   = UW'(REPEAT_UNITS + FRAME_UNITS);

    logic          key_prev;
    logic          in_first, in_second;
    logic [UW-1:0] rel_unit, bit_idx, sub_unit;
    logic [KEY_BITS-1:0] aligned;
    logic          bit_val;

    assign restart = (state == TX_IDLE) && key_down && !key_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            unit_cnt <= '0;
            code_q   <= '0;
            key_prev <= 1'b0;
        end else begin
            key_prev <= key_down;
            case (state)
                TX_IDLE: begin
                    if (restart) begin
                        state    <= TX_LEAD;
                        unit_cnt <= '0;
                        code_q   <= key_code;
                    end
                end
                TX_LEAD: begin
                    if (unit_stb) begin
                        if (unit_cnt == LEAD_LAST) begin
                            state    <= TX_BURST;
                            unit_cnt <= '0;
                        end else begin
                            unit_cnt <= unit_cnt + 1'b1;
                        end
                    end
                end
                TX_BURST: begin
                    if (unit_stb) begin
                        if (unit_cnt == STOP_AT && !key_down) begin
                            state    <= TX_IDLE;
                            unit_cnt <= '0;
                        end else if (unit_cnt == PAIR_LAST) begin
                            unit_cnt <= '0;
                        end else begin
                            unit_cnt <= unit_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state    <= TX_IDLE;
                    unit_cnt <= '0;
                end
            endcase
        end
    end

    // Envelope shaping: frame window, bit select, duty compare
    always_comb begin
        in_first  = (state == TX_BURST) && (unit_cnt < FRAME_END);
        in_second = (state == TX_BURST) && (unit_cnt >= COPY_START)
                    && (unit_cnt < COPY_END);
        rel_unit  = in_second ? (unit_cnt - COPY_START) : unit_cnt;
        bit_idx   = rel_unit / UW'(BIT_UNITS);
        sub_unit  = rel_unit % UW'(BIT_UNITS);
        aligned   = code_q << bit_idx;
        bit_val   = aligned[KEY_BITS-1];
        envelope  = (in_first || in_second) &&
                    (sub_unit < (bit_val ? UW'(ONE_HIGH) : UW'(ZERO_HIGH)));
    end

endmodule

// File: rtl/ir_ppm_encoder.sv
module ir_ppm_encoder #(
    parameter int HALF_DIV     = 658,
    parameter int UNIT_TICKS   = 16,
    parameter int KEY_BITS     = 12,
    parameter int BIT_UNITS    = 4,
    parameter int ONE_HIGH     = 3,
    parameter int ZERO_HIGH    = 1,
    parameter int LEAD_UNITS   = 60,
    parameter int REPEAT_UNITS = 80,
    parameter int PAIR_UNITS   = 208
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_down,
    input  logic [KEY_BITS-1:0] key_code,
    output logic                ir_drive
);
    import ir_ppm_pkg::*;

    localparam int CNT_SPAN = (LEAD_UNITS > PAIR_UNITS) ? LEAD_UNITS : PAIR_UNITS;
    localparam int UW = safe_width(CNT_SPAN);

    logic                restart;
    logic                carrier;
    logic                period_tick;
    logic                unit_stb;
    logic                envelope;
    tx_state_t           state;
    logic [UW-1:0]       unit_cnt;
    logic [KEY_BITS-1:0] code_q;

    ir_carrier_gen #(.HALF_DIV(HALF_DIV)) u_carrier (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .carrier     (carrier),
        .period_tick (period_tick)
    );

    ir_unit_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .period_tick (period_tick),
        .unit_stb    (unit_stb)
    );

    ir_frame_seq #(
        .KEY_BITS     (KEY_BITS),
        .BIT_UNITS    (BIT_UNITS),
        .ONE_HIGH     (ONE_HIGH),
        .ZERO_HIGH    (ZERO_HIGH),
        .LEAD_UNITS   (LEAD_UNITS),
        .REPEAT_UNITS (REPEAT_UNITS),
        .PAIR_UNITS   (PAIR_UNITS),
        .UW           (UW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .key_down (key_down),
        .key_code (key_code),
        .unit_stb (unit_stb),
        .restart  (restart),
        .state    (state),
        .unit_cnt (unit_cnt),
        .code_q   (code_q),
        .envelope (envelope)
    );

    assign ir_drive = envelope && carrier;

endmodule

// File: rtl/ir_ppm_checker.sv
module ir_ppm_checker #(
    parameter int KEY_BITS     = 12,
    parameter int BIT_UNITS    = 4,
    parameter int REPEAT_UNITS = 80,
    parameter int PAIR_UNITS   = 208,
    parameter int UW           = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ir_drive,
    input  logic                  envelope,
    input  logic                  carrier,
    input  logic                  unit_stb,
    input  ir_ppm_pkg::tx_state_t state,
    input  logic [UW-1:0]         unit_cnt,
    input  logic [KEY_BITS-1:0]   code_q
);
    import ir_ppm_pkg::*;

    localparam int FRAME_UNITS = KEY_BITS * BIT_UNITS;

    // R9
    drive_gated_chk: assert property (@(posedge clk) disable iff (rst)
        ir_drive |-> (envelope && carrier));

    // R2
    lead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_LEAD) |-> !envelope);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> !ir_drive);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != TX_IDLE && $past(state) != TX_IDLE) |-> $stable(code_q));

    // R5
    copy_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_BURST && unit_cnt >= UW'(FRAME_UNITS)
         && unit_cnt < UW'(REPEAT_UNITS)) |-> !envelope);

    // R6
    pair_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_BURST && unit_stb && unit_cnt == UW'(PAIR_UNITS - 1))
        |=> (state == TX_BURST && unit_cnt == '0));

endmodule

bind ir_ppm_encoder ir_ppm_checker #(
    .KEY_BITS     (KEY_BITS),
    .BIT_UNITS    (BIT_UNITS),
    .REPEAT_UNITS (REPEAT_UNITS),
    .PAIR_UNITS   (PAIR_UNITS),
    .UW           (UW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ir_drive (ir_drive),
    .envelope (envelope),
    .carrier  (carrier),
    .unit_stb (unit_stb),
    .state    (state),
    .unit_cnt (unit_cnt),
    .code_q   (code_q)
);

// File: tb/ir_ppm_encoder_bench.sv
`timescale 1ns/1ps
module ir_ppm_encoder_bench;

    localparam int HALF = 1;
    localparam int UNIT = 2 * HALF * 16;   // clocks per unit

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_down = 1'b0;
    logic [11:0] key_code = '0;
    logic        ir_drive;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = !clk;

    ir_ppm_encoder #(.HALF_DIV(HALF)) u_ir_ppm_encoder (
        .clk      (clk),
        .rst      (rst),
        .key_down (key_down),
        .key_code (key_code),
        .ir_drive (ir_drive)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run did not end, actual=%0d expected<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Number of pairs sent when the key is released after sample rel_t
    function automatic int pair_count(input int rel_t);
        for (int p = 0; p < 100; p++) begin
            if ((60 + 208 * p + 128) * UNIT > rel_t) return p + 1;
        end
        return 100;
    endfunction

    // Region of a cycle: 0 lead, 1 frame, 2 copy gap, 3 pair gap, 4 tail
    function automatic int region_of(input int t, input int rel_t);
        int u, w, r, u_end;
        u = t / UNIT;
        u_end = 60 + 208 * (pair_count(rel_t) - 1) + 128;
        if (u < 60) return 0;
        if (u >= u_end) return 4;
        w = u - 60;
        r = w % 208;
        if (r < 48 || (r >= 80 && r < 128)) return 1;
        if (r < 80) return 2;
        return 3;
    endfunction

    function automatic bit exp_drive(input int t, input logic [11:0] code, input int rel_t);
        int u, r, rel, b, s;
        if (region_of(t, rel_t) != 1) return 1'b0;
        if ((t % (2 * HALF)) >= HALF) return 1'b0;
        u = t / UNIT;
        r = (u - 60) % 208;
        rel = (r >= 80) ? r - 80 : r;
        b = rel / 4;
        s = rel % 4;
        return (s < (code[11 - b] ? 3 : 1));
    endfunction

    // Press, compare every cycle, release after sample rel_t,
    // optionally change key_code after sample chg_t
    task automatic run_burst(input logic [11:0] code, input int rel_t,
                             input int chg_t, input logic [11:0] chg_code,
                             input string name);
        int errs [5];
        int first_t [5];
        int first_a [5];
        int first_e [5];
        int stop_t;
        string tags [5];
        tags[0] = "R2 lead";
        tags[1] = "R3 R4 R9 frame";
        tags[2] = "R5 copy gap";
        tags[3] = "R6 pair gap";
        tags[4] = "R7 tail";
        for (int k = 0; k < 5; k++) begin
            errs[k] = 0; first_t[k] = -1; first_a[k] = 0; first_e[k] = 0;
        end
        stop_t = (60 + 208 * (pair_count(rel_t) - 1) + 128) * UNIT + 400;
        @(negedge clk);
        key_code = code;
        key_down = 1'b1;
        for (int t = 0; t <= stop_t; t++) begin
            int rg;
            bit e;
            @(negedge clk);
            rg = region_of(t, rel_t);
            e  = exp_drive(t, code, rel_t);
            if (ir_drive !== e) begin
                if (errs[rg] == 0) begin
                    first_t[rg] = t; first_a[rg] = int'(ir_drive); first_e[rg] = int'(e);
                end
                errs[rg]++;
            end
            if (t == rel_t) key_down = 1'b0;
            if (t == chg_t) key_code = chg_code;
        end
        for (int k = 0; k < 5; k++) begin
            if (k == 3 && pair_count(rel_t) < 2) continue;
            if (errs[k] != 0)
                $display("  %s: %s first mismatch at cycle %0d", name, tags[k], first_t[k]);
            check(errs[k] == 0, {name, " ", tags[k]}, first_a[k], first_e[k]);
        end
    endtask

    task automatic t_reset;
        int highs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (ir_drive) highs++;
        end
        check(highs == 0, "R1 quiet after reset", highs, 0);
    endtask

    task automatic t_idle_code_change;
        int highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            key_code = 12'(i * 37);
            if (ir_drive) highs++;
        end
        check(highs == 0, "R1 code change while idle", highs, 0);
    endtask

    task automatic t_single_pair;
        // R7: release during lead still sends one full pair
        run_burst(12'hA5C, 100, -1, 12'h000, "single");
    endtask

    task automatic t_two_pairs;
        // R6 R7: release mid second pair, both of its copies complete
        run_burst(12'h3F0, (60 + 208 + 30) * UNIT, -1, 12'h000, "two_pairs");
    endtask

    task automatic t_code_change;
        // R8: key code altered during the burst must not show
        run_burst(12'h801, 200, 500, 12'h7FE, "R8 latch");
    endtask

    task automatic t_extremes;
        run_burst(12'hFFF, 10, -1, 12'h000, "ones");
        run_burst(12'h000, 10, -1, 12'h000, "zeros");
    endtask

    task automatic gap;
        key_down = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle_code_change();
        t_single_pair();
        gap();
        t_two_pairs();
        gap();
        t_code_change();
        gap();
        t_extremes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule